// File: doc/BRIEF.md
# VME Bus Location Monitor

This block snoops every data transfer cycle on a VME-style backplane, no matter which master is driving it. It compares each cycle against one programmed location and emits a single-clock trigger when the cycle matches. The trigger drives a front-panel pin. Pin drivers, the register programming path and the pin routing are outside the block. Software sets the compare fields through plain configuration inputs, and the monitor then reacts to cycles from this board and from foreign masters in the same way.

The bus-side inputs are the address, the address modifier, and the active-low LWORD*, WRITE*, IACK* and AS* lines. They pass through a multi-stage synchronizer into the local clock domain. A capture register follows the synchronized bus while the strobe is idle and freezes once the strobe is seen asserted. Comparison therefore uses the values presented just before the strobe fell. All fields must match together, and the global enable must be set. A one-shot then produces exactly one pulse per strobe assertion.

Top module: `vme_loc_watch`

## Requirements
- R1: While `rst_n` is low and in the first cycles after its release, `trig` is low.
- R2: With `cfg_en` high and all fields matching, `trig` is high for the clock that follows the third rising edge at which `bus_as_n` is sampled low (two synchronizer stages plus one output register).
- R3: A mismatch in the upper 16 address bits (`cfg_addr_hi` against `bus_addr[31:16]`) suppresses the trigger.
- R4: A mismatch in the lower 16 address bits (`cfg_addr_lo` against `bus_addr[15:0]`) suppresses the trigger.
- R5: The 6-bit address modifier must equal `cfg_am` exactly, or no trigger is produced.
- R6: The flags `cfg_lword`, `cfg_write` and `cfg_iack` are active high and mean "expect the pin asserted". A value of 1 matches a bus pin at 0 and a value of 0 matches a pin at 1. Any flag that disagrees suppresses the trigger.
- R7: A matching strobe produces exactly one pulse, one clock wide, however long AS* stays asserted.
- R8: After AS* is deasserted for at least one synchronized clock, the next matching strobe fires again. Back-to-back matching cycles give one pulse each.
- R9: While `cfg_en` is low, `trig` stays low even for matching cycles.
- R10: The compare uses the bus values held at the strobe. Changes of address while AS* stays asserted neither create nor cancel a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Global enable of the monitor |
| cfg_addr_hi | input | 16 | Expected upper address half |
| cfg_addr_lo | input | 16 | Expected lower address half |
| cfg_am | input | 6 | Expected address modifier |
| cfg_lword | input | 1 | 1 = expect LWORD* asserted |
| cfg_write | input | 1 | 1 = expect WRITE* asserted (write cycle) |
| cfg_iack | input | 1 | 1 = expect IACK* asserted |
| bus_addr | input | 32 | Bus address lines |
| bus_am | input | 6 | Bus address modifier lines |
| bus_lword_n | input | 1 | Bus LWORD*, active low |
| bus_write_n | input | 1 | Bus WRITE*, active low |
| bus_iack_n | input | 1 | Bus IACK*, active low |
| bus_as_n | input | 1 | Bus address strobe, active low |
| trig | output | 1 | One-clock location trigger |

## Verification
A wrong capture register shows up as a missing or spurious pulse on `trig` three clocks after the strobe falls. This is most visible when the address moves during an asserted strobe. A stuck or wrongly re-armed one-shot shows as a second pulse within the same strobe, or as no pulse on the following back-to-back cycle. Both show within a single bus cycle. The bench runs a clock-by-clock model of the synchronizer, capture and one-shot, so any such divergence is reported on the very clock where `trig` differs.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

   localparam int unsigned VLW_ADDR_W = 32;
   localparam int unsigned VLW_HALF_W = 16;
   localparam int unsigned VLW_AM_W   = 6;
   localparam int unsigned VLW_SYNC_N = 2;

   // programmed "expect asserted" bit against an active-low pin
   function automatic logic flag_ok(input logic want_asserted, input logic pin_n);
      return want_asserted == ~pin_n;
   endfunction

endpackage

// File: rtl/vlw_sync.sv
module vlw_sync #(
   parameter int unsigned            W       = 8,
   parameter int unsigned            STAGES  = 2,
   parameter logic [W-1:0]           RST_PAT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_PAT;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_PAT;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/vlw_capture.sv
module vlw_capture #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe_idle,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   // follows the bus while the strobe is idle, freezes while it is asserted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= '0;
      else if (strobe_idle) q <= d;
   end

endmodule

// File: rtl/vlw_match.sv
module vlw_match #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned HALF_W  = 16,
   parameter int unsigned AM_W    = 6,
   parameter bit          CMP_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_act,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [AM_W-1:0]   held_am,
   input  logic              held_lword_n,
   input  logic              held_write_n,
   input  logic              held_iack_n,
   input  logic [ADDR_W-1:0] want_addr,
   input  logic [AM_W-1:0]   want_am,
   input  logic              want_lword,
   input  logic              want_write,
   input  logic              want_iack,
   output logic              hit
);
   import vlw_pkg::*;

   localparam int unsigned N_HALF = ADDR_W / HALF_W;

   logic [N_HALF-1:0] half_ok;
   logic              am_ok;
   logic              flags_ok;
   logic              hit_c;

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      assign half_ok[h] = held_addr[h*HALF_W +: HALF_W] == want_addr[h*HALF_W +: HALF_W];
   end

   assign am_ok    = held_am == want_am;
   assign flags_ok = flag_ok(want_lword, held_lword_n)
                   & flag_ok(want_write, held_write_n)
                   & flag_ok(want_iack,  held_iack_n);
   assign hit_c    = as_act & (&half_ok) & am_ok & flags_ok;

   if (CMP_REG) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit_c;
      end
      assign hit = hit_q;
   end else begin : g_comb
      assign hit = hit_c;
   end

endmodule

// File: rtl/vlw_oneshot.sv
module vlw_oneshot (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic hit,
   input  logic as_act,
   output logic pulse
);

   logic armed_q;
   logic fire;

   assign fire = enable & hit & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         pulse   <= 1'b0;
      end else begin
         pulse <= fire;
         if (!as_act)   armed_q <= 1'b1;
         else if (fire) armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/vme_loc_watch.sv
module vme_loc_watch #(
   parameter int unsigned ADDR_W      = vlw_pkg::VLW_ADDR_W,
   parameter int unsigned HALF_W      = vlw_pkg::VLW_HALF_W,
   parameter int unsigned AM_W        = vlw_pkg::VLW_AM_W,
   parameter int unsigned SYNC_STAGES = vlw_pkg::VLW_SYNC_N,
   parameter bit          CMP_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [HALF_W-1:0] cfg_addr_hi,
   input  logic [HALF_W-1:0] cfg_addr_lo,
   input  logic [AM_W-1:0]   cfg_am,
   input  logic              cfg_lword,
   input  logic              cfg_write,
   input  logic              cfg_iack,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [AM_W-1:0]   bus_am,
   input  logic              bus_lword_n,
   input  logic              bus_write_n,
   input  logic              bus_iack_n,
   input  logic              bus_as_n,
   output logic              trig
);

   localparam int unsigned HOLD_W = ADDR_W + AM_W + 3;
   localparam int unsigned BUS_W  = HOLD_W + 1;
   localparam logic [BUS_W-1:0] SYNC_RST = {{(ADDR_W+AM_W){1'b0}}, 4'b1111};

   // elaboration-time parameter checks
   if (ADDR_W != 2 * HALF_W) begin : g_bad_split
      $error("vme_loc_watch: ADDR_W must be twice HALF_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vme_loc_watch: SYNC_STAGES must be at least 2");
   end
   if (AM_W < 1 || AM_W > 8) begin : g_bad_am
      $error("vme_loc_watch: AM_W out of range");
   end

   logic [BUS_W-1:0]  bus_raw;
   logic [BUS_W-1:0]  bus_s;
   logic [HOLD_W-1:0] held;
   logic              as_act;
   logic              hit;

   logic [ADDR_W-1:0] held_addr;
   logic [AM_W-1:0]   held_am;
   logic              held_lword_n;
   logic              held_write_n;
   logic              held_iack_n;

   assign bus_raw = {bus_addr, bus_am, bus_lword_n, bus_write_n, bus_iack_n, bus_as_n};

   vlw_sync #(
      .W       (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_PAT (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_raw),
      .q     (bus_s)
   );

   assign as_act = ~bus_s[0];

   vlw_capture #(
      .W (HOLD_W)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_idle (bus_s[0]),
      .d           (bus_s[BUS_W-1:1]),
      .q           (held)
   );

   assign {held_addr, held_am, held_lword_n, held_write_n, held_iack_n} = held;

   vlw_match #(
      .ADDR_W  (ADDR_W),
      .HALF_W  (HALF_W),
      .AM_W    (AM_W),
      .CMP_REG (CMP_REG)
   ) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .as_act       (as_act),
      .held_addr    (held_addr),
      .held_am      (held_am),
      .held_lword_n (held_lword_n),
      .held_write_n (held_write_n),
      .held_iack_n  (held_iack_n),
      .want_addr    ({cfg_addr_hi, cfg_addr_lo}),
      .want_am      (cfg_am),
      .want_lword   (cfg_lword),
      .want_write   (cfg_write),
      .want_iack    (cfg_iack),
      .hit          (hit)
   );

   vlw_oneshot u_shot (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (cfg_en),
      .hit    (hit),
      .as_act (as_act),
      .pulse  (trig)
   );

endmodule

// File: rtl/vlw_chk.sv
module vlw_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned HALF_W  = 16,
   parameter bit          CMP_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic [HALF_W-1:0] cfg_addr_hi,
   input logic [HALF_W-1:0] cfg_addr_lo,
   input logic              as_act,
   input logic [ADDR_W-1:0] held_addr,
   input logic              trig
);

   localparam int unsigned LAT = 1 + CMP_REG;

   logic [1:0] pulses_in_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            pulses_in_strobe <= '0;
      else if (!as_act)                      pulses_in_strobe <= '0;
      else if (trig && pulses_in_strobe < 2) pulses_in_strobe <= pulses_in_strobe + 2'd1;
   end

   p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |-> !trig);

   p_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(as_act, LAT));

   p_addr_halves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(held_addr == {cfg_addr_hi, cfg_addr_lo}, LAT));

   p_one_clock_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);

   p_one_per_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulses_in_strobe < 2);

   p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(cfg_en));

endmodule

bind vme_loc_watch vlw_chk #(
   .ADDR_W  (ADDR_W),
   .HALF_W  (HALF_W),
   .CMP_REG (CMP_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .cfg_addr_hi (cfg_addr_hi),
   .cfg_addr_lo (cfg_addr_lo),
   .as_act      (as_act),
   .held_addr   (held_addr),
   .trig        (trig)
);

// File: tb/tb_vme_loc_watch.sv
`timescale 1ns/1ps
module tb_vme_loc_watch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [15:0] cfg_addr_hi = '0;
   logic [15:0] cfg_addr_lo = '0;
   logic [5:0]  cfg_am = '0;
   logic        cfg_lword = 1'b0;
   logic        cfg_write = 1'b0;
   logic        cfg_iack = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [5:0]  bus_am = '0;
   logic        bus_lword_n = 1'b1;
   logic        bus_write_n = 1'b1;
   logic        bus_iack_n = 1'b1;
   logic        bus_as_n = 1'b1;
   logic        trig;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   vme_loc_watch dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
      .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo), .cfg_am(cfg_am),
      .cfg_lword(cfg_lword), .cfg_write(cfg_write), .cfg_iack(cfg_iack),
      .bus_addr(bus_addr), .bus_am(bus_am), .bus_lword_n(bus_lword_n),
      .bus_write_n(bus_write_n), .bus_iack_n(bus_iack_n), .bus_as_n(bus_as_n),
      .trig(trig)
   );

   // ---------------- behavioural reference model ----------------
   // pipeline of sampled bus words: index 0 = first sync stage, 1 = second
   logic [31:0] m_addr [2];
   logic [5:0]  m_am   [2];
   logic [3:0]  m_ctl  [2];   // {lword_n, write_n, iack_n, as_n}
   logic [31:0] m_haddr;
   logic [5:0]  m_ham;
   logic [2:0]  m_hflg;
   logic        m_armed;
   logic        m_trig;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_addr[i] = '0; m_am[i] = '0; m_ctl[i] = 4'hF;
         end
         m_haddr = '0; m_ham = '0; m_hflg = '0;
         m_armed = 1'b1; m_trig = 1'b0;
      end else begin
         logic strobe, eq, fire;
         strobe = !m_ctl[1][0];
         eq = (m_haddr == {cfg_addr_hi, cfg_addr_lo}) && (m_ham == cfg_am)
              && (cfg_lword == !m_hflg[2]) && (cfg_write == !m_hflg[1])
              && (cfg_iack == !m_hflg[0]);
         fire = cfg_en && strobe && eq && m_armed;
         m_trig = fire;
         if (!strobe) m_armed = 1'b1;
         else if (fire) m_armed = 1'b0;
         if (!strobe) begin
            m_haddr = m_addr[1]; m_ham = m_am[1]; m_hflg = m_ctl[1][3:1];
         end
         m_addr[1] = m_addr[0]; m_am[1] = m_am[0]; m_ctl[1] = m_ctl[0];
         m_addr[0] = bus_addr; m_am[0] = bus_am;
         m_ctl[0] = {bus_lword_n, bus_write_n, bus_iack_n, bus_as_n};
      end
   end

   // per-clock comparison and pulse statistics, away from the active edge
   int pulse_cnt = 0;
   int run_len = 0;
   int max_run = 0;
   always @(negedge clk) begin
      checks++;
      if (trig !== m_trig) begin
         errors++;
         $display("FAIL %s: trig actual %b expected %b at %0t", cur_tag, trig, m_trig, $time);
      end
      if (trig === 1'b1) begin
         run_len++;
         if (run_len == 1) pulse_cnt++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one bus cycle: present fields, settle, assert AS*, optionally move the address
   task automatic bus_cycle(input logic [31:0] a, input logic [5:0] am,
                            input logic lw_n, input logic wr_n, input logic ia_n,
                            input int pre, input int hold,
                            input bit move, input logic [31:0] a2);
      bus_addr = a; bus_am = am; bus_lword_n = lw_n; bus_write_n = wr_n; bus_iack_n = ia_n;
      bus_as_n = 1'b1;
      idle(pre);
      bus_as_n = 1'b0;
      idle(1);
      if (move) bus_addr = a2;
      idle(hold);
      bus_as_n = 1'b1;
   endtask

   task automatic scenario(input string tag, input logic [31:0] a, input logic [5:0] am,
                           input logic lw_n, input logic wr_n, input logic ia_n,
                           input int hold, input bit move, input logic [31:0] a2,
                           input int exp_pulses);
      cur_tag = tag;
      pulse_cnt = 0; max_run = 0;
      bus_cycle(a, am, lw_n, wr_n, ia_n, 3, hold, move, a2);
      idle(5);
      check_eq({tag, " pulse count"}, pulse_cnt, exp_pulses);
   endtask

   localparam logic [31:0] TGT = 32'hA5C3_1E70;

   initial begin
      fork
         begin
            #(200000 * 10);
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none

      cfg_addr_hi = TGT[31:16]; cfg_addr_lo = TGT[15:0];
      cfg_am = 6'h0D; cfg_lword = 1'b1; cfg_write = 1'b0; cfg_iack = 1'b0;
      idle(3);
      check_eq("R1 trig in reset", int'(trig), 0);
      rst_n = 1'b1;
      idle(4);
      check_eq("R1 trig after reset", int'(trig), 0);

      cfg_en = 1'b1;
      // R2: full match (LWORD* low, WRITE* high = read, IACK* high); exact timing
      cur_tag = "R2";
      pulse_cnt = 0;
      bus_addr = TGT; bus_am = 6'h0D; bus_lword_n = 1'b0; bus_write_n = 1'b1; bus_iack_n = 1'b1;
      idle(3);
      bus_as_n = 1'b0;
      idle(2);
      check_eq("R2 no trig before third edge", int'(trig), 0);
      idle(1);
      check_eq("R2 trig after third edge", int'(trig), 1);
      idle(3);
      bus_as_n = 1'b1;
      idle(5);
      check_eq("R2 single pulse", pulse_cnt, 1);

      scenario("R3", TGT ^ 32'h0100_0000, 6'h0D, 1'b0, 1'b1, 1'b1, 4, 1'b0, '0, 0);
      scenario("R4", TGT ^ 32'h0000_0001, 6'h0D, 1'b0, 1'b1, 1'b1, 4, 1'b0, '0, 0);
      scenario("R5", TGT, 6'h09, 1'b0, 1'b1, 1'b1, 4, 1'b0, '0, 0);
      scenario("R6 lword", TGT, 6'h0D, 1'b1, 1'b1, 1'b1, 4, 1'b0, '0, 0);
      scenario("R6 write", TGT, 6'h0D, 1'b0, 1'b0, 1'b1, 4, 1'b0, '0, 0);
      scenario("R6 iack", TGT, 6'h0D, 1'b0, 1'b1, 1'b0, 4, 1'b0, '0, 0);

      // R6 inverted programming: expect write, interrupt ack, no long word
      cfg_write = 1'b1; cfg_iack = 1'b1; cfg_lword = 1'b0;
      scenario("R6 inverted flags", TGT, 6'h0D, 1'b1, 1'b0, 1'b0, 4, 1'b0, '0, 1);
      cfg_write = 1'b0; cfg_iack = 1'b0; cfg_lword = 1'b1;

      // R7: long strobe gives one pulse of one clock
      scenario("R7", TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 40, 1'b0, '0, 1);
      check_eq("R7 pulse width", max_run, 1);

      // R8: back-to-back matching cycles, AS* high for one clock between
      cur_tag = "R8";
      pulse_cnt = 0;
      bus_cycle(TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 3, 4, 1'b0, '0);
      bus_cycle(TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 1, 4, 1'b0, '0);
      bus_cycle(TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 1, 4, 1'b0, '0);
      idle(5);
      check_eq("R8 pulses for three cycles", pulse_cnt, 3);

      // R9: enable low blocks a matching cycle
      cfg_en = 1'b0;
      scenario("R9", TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 6, 1'b0, '0, 0);
      cfg_en = 1'b1;

      // R10: address moves after the strobe
      scenario("R10 keep match", TGT, 6'h0D, 1'b0, 1'b1, 1'b1, 6, 1'b1, 32'h0000_0000, 1);
      scenario("R10 no late match", 32'h1234_5678, 6'h0D, 1'b0, 1'b1, 1'b1, 6, 1'b1, TGT, 0);

      idle(4);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule